// File: doc/BRIEF.md
# Maskable Interrupt Aggregator with Write-One-to-Clear Acknowledge

This block gathers a parameterised set of interrupt lines into one request for a processor. Each line is watched for a low-to-high transition. A transition sets a sticky pending flag, and the flag stays set until software clears it. A per-line enable mask picks which pending flags may reach the request. A global gate bit can then hold the request low or let it through. The request output is registered.

Software reaches four word-wide registers over a simple register port. A read returns its data one cycle after the strobe. The pending flags can only be read. The mask and the global gate can be read and written. The clear register can only be written: a 1 in any bit position removes the matching pending flag, and the stored pattern empties itself on the next cycle. In every register, line k sits at data bit k, so line 0 is the least significant bit.

Top module: `intc_core`

## Requirements
- R1: After synchronous reset, the pending word, the mask word and the gate bit all read 0, and `irq_out` is 0.
- R2: A 0-to-1 transition on `irq_in[k]` sets pending bit k (data bit k at address 0). A line held high sets the bit only once.
- R3: Mask register (address 1) reads back what was written in bits 0..NUM_IN-1. Bits at and above NUM_IN read 0 and ignore writes.
- R4: Clearing a line's mask bit does not clear its pending bit. The bit stays readable until it is acknowledged.
- R5: `irq_out` goes to 1 one cycle after the gate is set and a line is both pending and unmasked, including when a line that is already pending is unmasked.
- R6: The gate is data bit 0 at address 3. While it is 0, `irq_out` is 0 one cycle later.
- R7: Writing 1s to the clear register (address 2) removes those pending bits one cycle after the write. Writing 0s, or writing 1s to bits that are not pending or have no input, changes nothing.
- R8: The clear register reads 0 and empties itself one cycle after a write, so a later transition on an acknowledged line pends again.
- R9: If a new transition and a clear of the same bit land in the same cycle, the bit stays pending.
- R10: Writes to the pending register (address 0) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IN | Interrupt lines, synchronous to clk |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 pending, 1 mask, 2 clear, 3 gate |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, updated the cycle after a read strobe and held otherwise |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with DATA_W = 16 and NUM_IN = 6, so the register word has ten bits with no input behind them. This lets the bench show that writing all ones to the mask leaves only the low six bits set. It also shows that an all-ones clear pattern has no effect on those missing lines. The bench moves line 5, the highest line that exists, to check the top of the implemented range. A directed sequence lines a fresh transition up with the cycle in which the clear register is active, which checks R9.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Register select codes on bus_addr
  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_EN   = 2'd1,
    REG_ACK  = 2'd2,
    REG_ME   = 2'd3
  } intc_reg_e;

  localparam int ADDR_W = 2;
  localparam int ME_BIT = 0;

endpackage

// File: rtl/intc_pend.sv
module intc_pend #(
  parameter int NUM_IN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic [NUM_IN-1:0] ack_i,
  output logic [NUM_IN-1:0] pend_o
);

  logic [NUM_IN-1:0] prev_q;
  logic [NUM_IN-1:0] pend_q;
  logic [NUM_IN-1:0] rise;

  for (genvar k = 0; k < NUM_IN; k++) begin : g_line
    assign rise[k] = irq_in[k] & ~prev_q[k];

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q[k] <= 1'b0;
        pend_q[k] <= 1'b0;
      end else begin
        prev_q[k] <= irq_in[k];
        // a fresh edge overrides a simultaneous clear
        pend_q[k] <= rise[k] | (pend_q[k] & ~ack_i[k]);
      end
    end
  end

  assign pend_o = pend_q;

  // R7
  ack_clr_chk: assert property (@(posedge clk) disable iff (rst)
    |(ack_i & ~rise) |=> ((pend_q & $past(ack_i & ~rise)) == '0));

  // R9
  edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
    |rise |=> ((pend_q & $past(rise)) == $past(rise)));

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    |(pend_q & ~ack_i) |=> ((pend_q & $past(pend_q & ~ack_i)) == $past(pend_q & ~ack_i)));

endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_IN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_IN-1:0] pend_i,
  output logic [NUM_IN-1:0] en_o,
  output logic [NUM_IN-1:0] ack_o,
  output logic              me_o
);

  logic [NUM_IN-1:0] en_q;
  logic [NUM_IN-1:0] ack_q;
  logic              me_q;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_stb;
  logic              rd_stb;
  logic              ack_wr;
  logic              unused_wdata;

  assign wr_stb = bus_sel & bus_wr;
  assign rd_stb = bus_sel & ~bus_wr;
  assign ack_wr = wr_stb && (intc_reg_e'(bus_addr) == REG_ACK);
  assign unused_wdata = ^bus_wdata;

  always_comb begin
    rd_mux = '0;
    case (intc_reg_e'(bus_addr))
      REG_STAT: rd_mux[NUM_IN-1:0] = pend_i;
      REG_EN:   rd_mux[NUM_IN-1:0] = en_q;
      REG_ME:   rd_mux[ME_BIT]     = me_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      ack_q <= '0;
      me_q  <= 1'b0;
      rd_q  <= '0;
    end else begin
      ack_q <= '0;
      if (wr_stb) begin
        case (intc_reg_e'(bus_addr))
          REG_EN:  en_q  <= bus_wdata[NUM_IN-1:0];
          REG_ACK: ack_q <= bus_wdata[NUM_IN-1:0];
          REG_ME:  me_q  <= bus_wdata[ME_BIT];
          default: ;
        endcase
      end
      if (rd_stb) rd_q <= rd_mux;
    end
  end

  assign en_o      = en_q;
  assign ack_o     = ack_q;
  assign me_o      = me_q;
  assign bus_rdata = rd_q;

  // R8
  ack_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (|ack_q && !ack_wr) |=> (ack_q == '0));

  // R10
  stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && intc_reg_e'(bus_addr) == REG_STAT) |=> ($stable(en_q) && $stable(me_q)));

endmodule

// File: rtl/intc_irq_out.sv
module intc_irq_out #(
  parameter int NUM_IN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] pend_i,
  input  logic [NUM_IN-1:0] en_i,
  input  logic              me_i,
  output logic              irq_o
);

  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= me_i & (|(pend_i & en_i));
  end

  assign irq_o = irq_q;

  // R6
  me_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !me_i |=> !irq_q);

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(|(pend_i & en_i)));

endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_IN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);

  logic [NUM_IN-1:0] pend;
  logic [NUM_IN-1:0] en;
  logic [NUM_IN-1:0] ack;
  logic              me;

  intc_pend #(.NUM_IN(NUM_IN)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .irq_in (irq_in),
    .ack_i  (ack),
    .pend_o (pend)
  );

  intc_regs #(.DATA_W(DATA_W), .NUM_IN(NUM_IN)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pend_i    (pend),
    .en_o      (en),
    .ack_o     (ack),
    .me_o      (me)
  );

  intc_irq_out #(.NUM_IN(NUM_IN)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .pend_i (pend),
    .en_i   (en),
    .me_i   (me),
    .irq_o  (irq_out)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !irq_out);

endmodule

// File: tb/sim_intc_core.sv
module sim_intc_core;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NI = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NI-1:0] irq_in = '0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_core #(.DATA_W(DW), .NUM_IN(NI)) u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // kind: 0 = lines only, 1 = write, 2 = read and compare
  typedef struct packed {
    logic [1:0]    kind;
    logic [1:0]    addr;
    logic [DW-1:0] data;
    logic [NI-1:0] lines;
    logic [DW-1:0] exp_rd;
    logic          exp_irq;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 2'd0, 16'h0000, 6'h00, 16'h0000, 1'b0}, // R1 pending 0
    '{2'd2, 2'd1, 16'h0000, 6'h00, 16'h0000, 1'b0}, // R1 mask 0
    '{2'd1, 2'd1, 16'hFFFF, 6'h00, 16'h0000, 1'b0}, // R3 write all ones
    '{2'd2, 2'd1, 16'h0000, 6'h00, 16'h003F, 1'b0}, // R3 only low bits kept
    '{2'd1, 2'd3, 16'h0001, 6'h00, 16'h0000, 1'b0}, // R6 gate on
    '{2'd0, 2'd0, 16'h0000, 6'h01, 16'h0000, 1'b1}, // R2 R5 line 0 rises
    '{2'd2, 2'd0, 16'h0000, 6'h01, 16'h0001, 1'b1}, // R2 pending bit 0
    '{2'd1, 2'd1, 16'h0000, 6'h01, 16'h0000, 1'b0}, // R4 mask off
    '{2'd2, 2'd0, 16'h0000, 6'h01, 16'h0001, 1'b0}, // R4 still pending
    '{2'd1, 2'd1, 16'h0001, 6'h01, 16'h0000, 1'b1}, // R5 unmask pending line
    '{2'd1, 2'd3, 16'h0000, 6'h01, 16'h0000, 1'b0}, // R6 gate off
    '{2'd1, 2'd3, 16'h0001, 6'h01, 16'h0000, 1'b1}, // R6 gate on again
    '{2'd1, 2'd2, 16'h0000, 6'h01, 16'h0000, 1'b1}, // R7 zero clear
    '{2'd1, 2'd2, 16'h003E, 6'h01, 16'h0000, 1'b1}, // R7 clear of idle bits
    '{2'd1, 2'd2, 16'h0001, 6'h01, 16'h0000, 1'b0}, // R7 R2 clear, line held high
    '{2'd2, 2'd0, 16'h0000, 6'h01, 16'h0000, 1'b0}, // R7 pending gone
    '{2'd2, 2'd2, 16'h0000, 6'h01, 16'h0000, 1'b0}, // R8 clear reg reads 0
    '{2'd0, 2'd0, 16'h0000, 6'h00, 16'h0000, 1'b0}, // R2 line 0 falls
    '{2'd0, 2'd0, 16'h0000, 6'h20, 16'h0000, 1'b0}, // R2 masked line 5 rises
    '{2'd2, 2'd0, 16'h0000, 6'h20, 16'h0020, 1'b0}, // R2 R4 bit 5 pending
    '{2'd1, 2'd0, 16'h0000, 6'h20, 16'h0000, 1'b0}, // R10 write pending reg
    '{2'd2, 2'd0, 16'h0000, 6'h20, 16'h0020, 1'b0}, // R10 unchanged
    '{2'd1, 2'd1, 16'h0021, 6'h20, 16'h0000, 1'b1}, // R5 unmask line 5
    '{2'd1, 2'd2, 16'hFFFF, 6'h20, 16'h0000, 1'b0}, // R7 all-ones clear
    '{2'd2, 2'd0, 16'h0000, 6'h20, 16'h0000, 1'b0}, // R7 nothing left
    '{2'd0, 2'd0, 16'h0000, 6'h01, 16'h0000, 1'b1}, // R8 line 0 pends again
    '{2'd2, 2'd0, 16'h0000, 6'h01, 16'h0001, 1'b1}  // R8 pending bit 0
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after reset", {15'd0, irq_out}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      irq_in = VEC[i].lines;
      if (VEC[i].kind != 2'd0) begin
        bus_sel = 1'b1; bus_wr = (VEC[i].kind == 2'd1);
        bus_addr = VEC[i].addr; bus_wdata = VEC[i].data;
      end
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk($sformatf("vector %0d irq", i), {15'd0, irq_out}, {15'd0, VEC[i].exp_irq});
      if (VEC[i].kind == 2'd2)
        chk($sformatf("vector %0d rdata", i), bus_rdata, VEC[i].exp_rd);
    end

    // R9: line 1 pends, then a clear of bit 1 meets a fresh edge on line 1
    @(negedge clk); irq_in = 6'h03;
    @(negedge clk); irq_in = 6'h01;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 16'h0002;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; irq_in = 6'h03;
    @(negedge clk);
    bus_op(1'b0, 2'd0, '0);
    chk("R9 edge beats clear", bus_rdata, 16'h0003);
    bus_op(1'b1, 2'd2, 16'h0002);
    bus_op(1'b0, 2'd0, '0);
    chk("R7 plain clear of bit 1", bus_rdata, 16'h0001);

    // R1: reset mid-run returns all state to zero
    @(negedge clk); irq_in = '0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R1 irq in reset", {15'd0, irq_out}, 16'd0);
    bus_op(1'b0, 2'd0, '0);
    chk("R1 pending cleared", bus_rdata, 16'h0000);
    bus_op(1'b0, 2'd1, '0);
    chk("R1 mask cleared", bus_rdata, 16'h0000);
    bus_op(1'b0, 2'd3, '0);
    chk("R1 gate cleared", bus_rdata, 16'h0000);

    // R6: gate stays off after reset even with a pending, unmasked line
    bus_op(1'b1, 2'd1, 16'h0004);
    @(negedge clk); irq_in = 6'h04;
    repeat (3) @(negedge clk);
    chk("R6 gate holds irq low", {15'd0, irq_out}, 16'd0);
    bus_op(1'b1, 2'd3, 16'h0001);
    chk("R5 R6 gate opens", {15'd0, irq_out}, 16'd1);

    summary();
  end

endmodule